// File: doc/BRIEF.md
# Buffered SPI Master Serial Controller

This block is a master-only SPI serial controller that moves 8-bit characters between a host and one peripheral. The host pushes characters into a four-entry transmit queue through a write strobe. It pulls received characters from a four-entry receive queue through a show-ahead read port: the head character is always visible, and a read strobe discards it. Each character sent on MOSI brings one character in on MISO. The serializer drains the transmit queue back to back, and the single chip select stays low for the whole run.

The host sets clock polarity, clock phase and bit order as independent inputs. The SCLK rate comes from a half-period count. Four status outputs report:
- transmit idle
- room in the transmit queue
- received data available
- a sticky receive overflow

For receive-only streams, the host can latch a repeat setting. While it is latched, the serializer keeps clocking after the transmit queue empties. It sends either the most recent host character again or an all-ones busy token, so the host does not have to feed dummy bytes.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset: transmit idle is 1, transmit free is 1, receive valid is 0, overflow is 0, repeat status is 0, chip select is high and SCLK sits at the polarity level.
- R2: SCLK has a period of 2*cfgHalfDiv system clocks, with a value of 0 treated as 1. Between runs SCLK rests at cfgCpol. Chip select is low for the whole of a run of back-to-back characters and rises once, after the last character.
- R3: MOSI changes at the start of each bit and is stable at the sampling edge. The sampling edge is the leading SCLK edge (the edge away from cfgCpol) when cfgCpha=0, and the trailing edge when cfgCpha=1. MISO is captured at the same mid-bit point.
- R4: With cfgLsbFirst=0, bit 7 is shifted first in both directions. With cfgLsbFirst=1, bit 0 is shifted first.
- R5: Transmit idle goes low in the cycle after a write into an empty, idle controller. It returns high only once the queue is empty and the last character has been completely shifted.
- R6: Transmit free is low exactly while the transmit queue holds 4 characters. It rises again once a character has been taken for shifting.
- R7: Each completed character enters the receive queue, and receive valid is high while at least one character is queued. Characters are read in arrival order.
- R8: A character that completes while the receive queue is full and not being read is dropped, and the overflow flag is set.
- R9: The overflow flag stays set until ovfClr is pulsed, or until a read leaves the receive queue empty. In the second case it clears one cycle after the queue becomes empty.
- R10: With repeat latched and the transmit queue empty at the end of a character, another character starts at once. It is all ones when cfgRepeatBusy=1, and otherwise the last character taken from the queue.
- R11: statRepeatOn takes the value of cfgRepeatReq only in cycles where the transmit queue is empty. A request raised and dropped while characters are queued has no effect.
- R12: A push and a pop on a queue in the same cycle leave its occupancy unchanged and lose no character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgCpol | input | 1 | SCLK idle level |
| cfgCpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| cfgLsbFirst | input | 1 | 1: least significant bit first |
| cfgRepeatReq | input | 1 | Requested repeat-mode setting |
| cfgRepeatBusy | input | 1 | Repeat content: 1 all-ones token, 0 last character |
| cfgHalfDiv | input | 8 | SCLK half period in system clocks |
| txWrEn | input | 1 | Push txWrData into the transmit queue |
| txWrData | input | 8 | Character to send |
| rxRdEn | input | 1 | Pop the receive queue head |
| rxRdData | output | 8 | Receive queue head |
| ovfClr | input | 1 | Clear the overflow flag |
| statTxIdle | output | 1 | Nothing queued or shifting |
| statTxFree | output | 1 | Transmit queue not full |
| statRxValid | output | 1 | Receive queue not empty |
| statRxOvf | output | 1 | Sticky receive overflow |
| statRepeatOn | output | 1 | Latched repeat setting |
| spiSclk | output | 1 | Serial clock |
| spiCsN | output | 1 | Active-low chip select |
| spiMosi | output | 1 | Serial data out |
| spiMiso | input | 1 | Serial data in |

## Verification
Two pairs of events can land on the same system clock edge.
- On the transmit side, the host's push can coincide with the serializer's pop. Five writes on consecutive cycles make the second write meet the first load. The scoreboard then requires all five characters on MOSI, in order.
- On the receive side, a character can complete while the queue is full. With the reader stopped, six characters are sent. The scoreboard expects only the first four back, and the overflow flag must be set.

MISO is looped back inverted from MOSI, so every received character has a known value. The MOSI monitor rebuilds each character at the sampling edges using its own mode and bit-order rules.

// File: rtl/spim_pkg.sv
package spim_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  // strobes from sequencing control to the shift datapath
  typedef struct packed {
    logic load;      // start a new character in the transmit shifter
    logic useFifo;   // load source: queue head (1) or repeat value (0)
    logic sample;    // capture MISO at mid-bit
    logic shiftOut;  // advance MOSI to the next bit
    logic finish;    // character complete, hand to receive queue
  } spimStrobe_t;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] popData,
  output logic             empty,
  output logic             full
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [CW-1:0]    count;
  logic             doPush, doPop;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign doPop   = pop && !empty;
  assign doPush  = push && (!full || doPop);
  assign popData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  AST_FIFO_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH)) else $error("fifo level above depth"); // R6

  AST_FIFO_PUSH_POP_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (push && pop && !empty) |=> (count == $past(count))) else $error("push+pop moved level"); // R12
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cpol,
  input  logic                 cpha,
  input  logic [DIV_W-1:0]     halfDiv,
  input  logic                 repeatReq,
  input  logic                 txEmpty,
  output spim_pkg::spimStrobe_t strobe,
  output logic                 busy,
  output logic                 repeatOn,
  output logic                 sclk,
  output logic                 csN
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [DIV_W-1:0] halfLen, halfCnt;
  logic             secondHalf;
  logic [BW-1:0]    bitCnt;
  logic             halfEnd, lastBit, moreData;

  assign halfLen  = (halfDiv == '0) ? DIV_W'(1) : halfDiv;
  assign halfEnd  = busy && (halfCnt == halfLen - DIV_W'(1));
  assign lastBit  = (bitCnt == BW'(DATA_W - 1));
  assign moreData = !txEmpty || repeatOn;

  assign sclk = cpol ^ (busy & (secondHalf ^ cpha));
  assign csN  = !busy;

  always_comb begin
    strobe = '0;
    if (!busy) begin
      if (!txEmpty) begin
        strobe.load    = 1'b1;
        strobe.useFifo = 1'b1;
      end
    end else if (halfEnd) begin
      if (!secondHalf) begin
        strobe.sample = 1'b1;
      end else if (!lastBit) begin
        strobe.shiftOut = 1'b1;
      end else begin
        strobe.finish = 1'b1;
        if (!txEmpty) begin
          strobe.load    = 1'b1;
          strobe.useFifo = 1'b1;
        end else if (repeatOn) begin
          strobe.load = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy       <= 1'b0;
      halfCnt    <= '0;
      secondHalf <= 1'b0;
      bitCnt     <= '0;
      repeatOn   <= 1'b0;
    end else begin
      if (txEmpty) repeatOn <= repeatReq;
      if (!busy) begin
        if (!txEmpty) begin
          busy       <= 1'b1;
          halfCnt    <= '0;
          secondHalf <= 1'b0;
          bitCnt     <= '0;
        end
      end else if (halfEnd) begin
        halfCnt    <= '0;
        secondHalf <= !secondHalf;
        if (secondHalf) begin
          bitCnt <= lastBit ? '0 : bitCnt + BW'(1);
          if (lastBit && !moreData) busy <= 1'b0;
        end
      end else begin
        halfCnt <= halfCnt + DIV_W'(1);
      end
    end
  end

  AST_HALF_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (halfCnt < halfLen)) else $error("half counter overran"); // R2

  AST_REPEAT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !txEmpty |=> $stable(repeatOn)) else $error("repeat changed with data queued"); // R11
endmodule

// File: rtl/spim_datapath.sv
module spim_datapath #(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  spim_pkg::spimStrobe_t strobe,
  input  logic                  lsbFirst,
  input  logic                  repeatBusy,
  input  logic [DATA_W-1:0]     fifoData,
  input  logic                  miso,
  input  logic                  rxFull,
  input  logic                  rxEmpty,
  input  logic                  rxPop,
  input  logic                  ovfClr,
  output logic                  mosi,
  output logic [DATA_W-1:0]     rxWord,
  output logic                  ovf
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [DATA_W-1:0] txShift, rxShift, lastChar, loadVal;
  logic              lastPop;

  assign loadVal = strobe.useFifo ? fifoData : (repeatBusy ? '1 : lastChar);
  assign mosi    = lsbFirst ? txShift[0] : txShift[DATA_W-1];
  assign rxWord  = rxShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift  <= '0;
      lastChar <= '0;
    end else if (strobe.load) begin
      txShift <= loadVal;
      if (strobe.useFifo) lastChar <= fifoData;
    end else if (strobe.shiftOut) begin
      txShift <= lsbFirst ? (txShift >> 1) : (txShift << 1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
    end else if (strobe.sample) begin
      rxShift <= lsbFirst ? {miso, rxShift[DATA_W-1:1]} : {rxShift[DATA_W-2:0], miso};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovf     <= 1'b0;
      lastPop <= 1'b0;
    end else begin
      lastPop <= rxPop && !rxEmpty;
      if (strobe.finish && rxFull && !rxPop) ovf <= 1'b1;
      else if (ovfClr || (lastPop && rxEmpty)) ovf <= 1'b0;
    end
  end

  AST_OVF_ON_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.finish && rxFull && !rxPop) |=> ovf) else $error("drop without overflow"); // R8

  AST_MOSI_MIDBIT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sample |=> $stable(mosi)) else $error("mosi moved at sample point"); // R3
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master #(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int DIV_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgCpol,
  input  logic              cfgCpha,
  input  logic              cfgLsbFirst,
  input  logic              cfgRepeatReq,
  input  logic              cfgRepeatBusy,
  input  logic [DIV_W-1:0]  cfgHalfDiv,
  input  logic              txWrEn,
  input  logic [DATA_W-1:0] txWrData,
  input  logic              rxRdEn,
  output logic [DATA_W-1:0] rxRdData,
  input  logic              ovfClr,
  output logic              statTxIdle,
  output logic              statTxFree,
  output logic              statRxValid,
  output logic              statRxOvf,
  output logic              statRepeatOn,
  output logic              spiSclk,
  output logic              spiCsN,
  output logic              spiMosi,
  input  logic              spiMiso
);
  timeunit 1ns;
  timeprecision 1ps;

  spim_pkg::spimStrobe_t strobe;
  logic [DATA_W-1:0] txHead, rxWord;
  logic txEmpty, txFull, rxEmpty, rxFull, busy;

  spim_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) i_txFifo (
    .clk(clk), .rstN(rstN), .push(txWrEn), .pushData(txWrData),
    .pop(strobe.load && strobe.useFifo), .popData(txHead),
    .empty(txEmpty), .full(txFull));

  spim_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) i_rxFifo (
    .clk(clk), .rstN(rstN), .push(strobe.finish), .pushData(rxWord),
    .pop(rxRdEn), .popData(rxRdData),
    .empty(rxEmpty), .full(rxFull));

  spim_ctrl #(.DATA_W(DATA_W), .DIV_W(DIV_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .cpol(cfgCpol), .cpha(cfgCpha), .halfDiv(cfgHalfDiv),
    .repeatReq(cfgRepeatReq), .txEmpty(txEmpty), .strobe(strobe), .busy(busy),
    .repeatOn(statRepeatOn), .sclk(spiSclk), .csN(spiCsN));

  spim_datapath #(.DATA_W(DATA_W)) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lsbFirst(cfgLsbFirst),
    .repeatBusy(cfgRepeatBusy), .fifoData(txHead), .miso(spiMiso),
    .rxFull(rxFull), .rxEmpty(rxEmpty), .rxPop(rxRdEn), .ovfClr(ovfClr),
    .mosi(spiMosi), .rxWord(rxWord), .ovf(statRxOvf));

  assign statTxIdle  = txEmpty && !busy;
  assign statTxFree  = !txFull;
  assign statRxValid = !rxEmpty;
endmodule

// File: tb/test_spi_fifo_master.sv
module test_spi_fifo_master;
  timeunit 1ns;
  timeprecision 1ps;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgCpol = 0, cfgCpha = 0, cfgLsbFirst = 0, cfgRepeatReq = 0, cfgRepeatBusy = 0;
  logic [7:0] cfgHalfDiv = 8'd2;
  logic txWrEn = 0, rxRdEn = 0, ovfClr = 0;
  logic [7:0] txWrData = '0, rxRdData;
  logic statTxIdle, statTxFree, statRxValid, statRxOvf, statRepeatOn;
  logic spiSclk, spiCsN, spiMosi, spiMiso;

  assign spiMiso = ~spiMosi;

  spi_fifo_master i_spi_fifo_master (
    .clk(clk), .rstN(rstN), .cfgCpol(cfgCpol), .cfgCpha(cfgCpha), .cfgLsbFirst(cfgLsbFirst),
    .cfgRepeatReq(cfgRepeatReq), .cfgRepeatBusy(cfgRepeatBusy), .cfgHalfDiv(cfgHalfDiv),
    .txWrEn(txWrEn), .txWrData(txWrData), .rxRdEn(rxRdEn), .rxRdData(rxRdData),
    .ovfClr(ovfClr), .statTxIdle(statTxIdle), .statTxFree(statTxFree),
    .statRxValid(statRxValid), .statRxOvf(statRxOvf), .statRepeatOn(statRepeatOn),
    .spiSclk(spiSclk), .spiCsN(spiCsN), .spiMosi(spiMosi), .spiMiso(spiMiso));

  always #2.5 clk = ~clk;

  int checks = 0, bad = 0;
  bit done = 0;
  logic [7:0] mosiQ[$];
  logic [7:0] rxQ[$];
  bit repValid = 0;
  logic [7:0] repTx = '0, repRx = '0;
  int repHits = 0;
  bit autoRd = 0;
  int csRise = 0;
  int bitIdx = 0;
  logic [7:0] shAcc = '0;
  realtime lastEdge = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  always @(posedge spiCsN) csRise++;

  // MOSI monitor: rebuild each character at the sampling edges (R3, R4, R2 period)
  always @(posedge spiSclk or negedge spiSclk) begin
    if (!spiCsN && ((spiSclk != cfgCpol) == !cfgCpha)) begin
      real expT;
      logic [7:0] expB;
      expT = 10.0 * ((cfgHalfDiv == 0) ? 1 : cfgHalfDiv);
      if (bitIdx != 0)
        chk(($realtime - lastEdge) > expT - 0.1 && ($realtime - lastEdge) < expT + 0.1,
            "R2 sclk period", int'($realtime - lastEdge), int'(expT));
      lastEdge = $realtime;
      shAcc = cfgLsbFirst ? {spiMosi, shAcc[7:1]} : {shAcc[6:0], spiMosi};
      bitIdx++;
      if (bitIdx == 8) begin
        bitIdx = 0;
        if (mosiQ.size() != 0) begin
          expB = mosiQ.pop_front();
          chk(shAcc == expB, cfgLsbFirst ? "R4 mosi char" : "R3 mosi char", shAcc, expB);
        end else if (repValid) begin
          chk(shAcc == repTx, "R10 mosi repeat char", shAcc, repTx);
        end else begin
          chk(1'b0, "R12 unexpected mosi char", shAcc, 0);
        end
      end
    end
  end

  // receive monitor: scoreboard pop and compare
  initial begin
    forever begin
      @(negedge clk);
      if (rxRdEn) rxRdEn = 0;
      else if (autoRd && statRxValid) begin
        if (rxQ.size() != 0) begin
          logic [7:0] e;
          e = rxQ.pop_front();
          chk(rxRdData == e, "R7 rx char", rxRdData, e);
        end else if (repValid) begin
          chk(rxRdData == repRx, "R10 rx repeat char", rxRdData, repRx);
          repHits++;
        end else begin
          chk(1'b0, "R8 unexpected rx char", rxRdData, 0);
        end
        rxRdEn = 1;
      end
    end
  end

  task automatic sendByte(input logic [7:0] b, input bit expectRx);
    while (!statTxFree) @(negedge clk);
    txWrData = b;
    txWrEn = 1;
    mosiQ.push_back(b);
    if (expectRx) rxQ.push_back(~b);
    @(negedge clk);
    txWrEn = 0;
  endtask

  task automatic waitIdle();
    do @(negedge clk); while (!statTxIdle);
  endtask

  task automatic drain();
    autoRd = 1;
    while (rxQ.size() != 0 || statRxValid) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    finishRun();
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk(statTxIdle == 1, "R1 idle", statTxIdle, 1);
    chk(statTxFree == 1, "R1 free", statTxFree, 1);
    chk(statRxValid == 0, "R1 rx valid", statRxValid, 0);
    chk(statRxOvf == 0, "R1 ovf", statRxOvf, 0);
    chk(statRepeatOn == 0, "R1 repeat", statRepeatOn, 0);
    chk(spiCsN == 1 && spiSclk == cfgCpol, "R1 cs/sclk", {spiCsN, spiSclk}, 2'b10);
    autoRd = 1;

    // all modes, bit orders and divisors
    for (int m = 0; m < 8; m++) begin
      int c0;
      cfgCpol = m[0]; cfgCpha = m[1]; cfgLsbFirst = m[2];
      cfgHalfDiv = 8'(m % 3);
      @(negedge clk);
      chk(spiSclk == cfgCpol, "R2 idle sclk level", spiSclk, cfgCpol);
      c0 = csRise;
      sendByte(8'hA5 ^ 8'(m * 37), 1);
      chk(statTxIdle == 0, "R5 idle cleared", statTxIdle, 0);
      sendByte(8'h1E + 8'(m), 1);
      sendByte(8'hC3 ^ 8'(m), 1);
      waitIdle();
      chk(mosiQ.size() == 0, "R5 idle before last char", mosiQ.size(), 0);
      chk(csRise - c0 == 1, "R2 single cs run", csRise - c0, 1);
      chk(spiSclk == cfgCpol, "R2 sclk rests", spiSclk, cfgCpol);
      drain();
    end

    // R6 / R12: five writes on consecutive cycles
    cfgCpol = 0; cfgCpha = 0; cfgLsbFirst = 0; cfgHalfDiv = 8'd10;
    @(negedge clk);
    for (int k = 0; k < 5; k++) sendByte(8'h30 + 8'(k), 1);
    chk(statTxFree == 0, "R6 full clears free", statTxFree, 0);
    while (!statTxFree) @(negedge clk);
    chk(statTxIdle == 0, "R6 free back while shifting", statTxIdle, 0);
    waitIdle();
    drain();
    chk(mosiQ.size() == 0 && rxQ.size() == 0, "R12 no lost char", mosiQ.size() + rxQ.size(), 0);

    // R8 / R9: overflow, cleared by reading empty
    cfgHalfDiv = 8'd1;
    autoRd = 0;
    @(negedge clk);
    for (int k = 0; k < 6; k++) sendByte(8'h50 + 8'(k), k < 4);
    waitIdle();
    chk(statRxValid == 1, "R7 rx valid", statRxValid, 1);
    chk(statRxOvf == 1, "R8 overflow set", statRxOvf, 1);
    drain();
    chk(statRxOvf == 0, "R9 cleared by read empty", statRxOvf, 0);

    // R9: cleared by ovfClr
    autoRd = 0;
    for (int k = 0; k < 5; k++) sendByte(8'h60 + 8'(k), k < 4);
    waitIdle();
    chk(statRxOvf == 1, "R8 overflow set again", statRxOvf, 1);
    repeat (3) @(negedge clk);
    chk(statRxOvf == 1, "R9 sticky", statRxOvf, 1);
    ovfClr = 1;
    @(negedge clk);
    ovfClr = 0;
    chk(statRxOvf == 0 && statRxValid == 1, "R9 cleared by ovfClr", {statRxOvf, statRxValid}, 2'b01);
    drain();

    // R10: repeat last character, then busy token
    for (int v = 0; v < 2; v++) begin
      cfgHalfDiv = 8'd2;
      cfgRepeatBusy = v[0];
      cfgRepeatReq = 1;
      @(negedge clk); @(negedge clk);
      chk(statRepeatOn == 1, "R11 latched when empty", statRepeatOn, 1);
      repTx = v[0] ? 8'hFF : 8'h3C;
      repRx = ~repTx;
      repHits = 0;
      repValid = 1;
      sendByte(v[0] ? 8'h81 : 8'h3C, 1);
      while (repHits < 3) @(negedge clk);
      cfgRepeatReq = 0;
      waitIdle();
      drain();
      chk(repHits >= 3, "R10 repeat chars", repHits, 3);
      chk(statRepeatOn == 0, "R11 released", statRepeatOn, 0);
      repValid = 0;
      cfgRepeatBusy = 0;
    end

    // R11: request while queue not empty is ignored
    cfgHalfDiv = 8'd8;
    @(negedge clk);
    sendByte(8'h11, 1); sendByte(8'h22, 1); sendByte(8'h33, 1);
    cfgRepeatReq = 1;
    @(negedge clk);
    @(negedge clk);
    chk(statRepeatOn == 0, "R11 ignored while queued", statRepeatOn, 0);
    cfgRepeatReq = 0;
    waitIdle();
    repeat (100) @(negedge clk);
    chk(spiCsN == 1 && statRepeatOn == 0, "R11 no repeat run", {spiCsN, statRepeatOn}, 2'b10);
    drain();
    chk(mosiQ.size() == 0, "R11 exact chars", mosiQ.size(), 0);

    finishRun();
  end
endmodule